// File: doc/BRIEF.md
# Receive Descriptor Run Controller

This block sequences the receive half of a descriptor-driven Ethernet DMA engine. A level run bit from software starts and stops the engine. The engine is always in one of three visible states: stopped, running or suspended. While running it fetches the descriptor at its current pointer and examines the ownership bit. It hands each descriptor that the DMA owns to a frame-transfer datapath and waits for that datapath to report the frame done. It then returns the descriptor to software through a write-back strobe and moves the pointer on to the next descriptor.

The first start after reset loads the pointer from the list base input. Every later start continues from wherever the engine halted. If the fetched descriptor still belongs to software, the engine suspends and raises a sticky flag. A poll pulse then makes it retry the same descriptor. A stop never cuts a frame short: the engine finishes the transfer in flight and its write-back, saves the advanced pointer, and only then reports stopped.

Top module: `rx_desc_run_ctrl`

## Requirements
- R1: After reset, rx_state is 00 (stopped), fetch_req, xfer_req and wb_valid are low, and susp_flag and stop_flag are 0.
- R2: The first start after reset (run_en high while stopped) moves rx_state to 01 (running) on the next clock and raises fetch_req with fetch_addr equal to list_base.
- R3: A fetched descriptor with fetch_own=1 produces xfer_req with xfer_addr equal to the fetched address. Both are held until xfer_done is seen.
- R4: xfer_done is accepted in the clock where it is high. In the next cycle wb_valid is high for exactly one cycle, and wb_addr equals the completed descriptor's address; this hands ownership back to software.
- R5: After a write-back the pointer moves on as follows. If the descriptor had fetch_chain=1, it goes to fetch_next with its low log2(DESC_BYTES) bits cleared. Otherwise, if fetch_ring_end=1, it goes to list_base. Otherwise it goes to the old pointer plus DESC_BYTES (16 by default).
- R6: A fetched descriptor with fetch_own=0 while run_en is high moves rx_state to 10 (suspended) and sets susp_flag. No xfer_req is raised.
- R7: In the suspended state a poll_req pulse starts a fetch of the same address, and running resumes if that fetch returns fetch_own=1. poll_req has no effect while stopped.
- R8: susp_flag (clear bit 0) and stop_flag (clear bit 1) remain set until a clock where the matching bit of clr_flags is 1. A set and a clear in the same cycle leave the flag set. Each clear bit leaves the other flag untouched.
- R9: Dropping run_en during a transfer keeps rx_state at 01 until xfer_done and the write-back have completed. After that rx_state becomes 00 and stop_flag is set.
- R10: A start after a stop fetches from the saved, advanced pointer and ignores any new list_base value.
- R11: A start is acted on only in the stopped state. If run_en rises again while a stop is pending, the stop still happens: rx_state is 00 for at least one cycle before the next fetch.
- R12: A stop from the suspended state gives rx_state 00 on the next clock. A stop requested during a fetch discards the descriptor that is returned. In both cases the pointer is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Software run bit (1 = run, 0 = stop) |
| list_base | input | AW | Receive descriptor list base address |
| poll_req | input | 1 | Poll-demand pulse |
| clr_flags | input | 2 | Write-1-to-clear: bit 0 susp_flag, bit 1 stop_flag |
| fetch_req | output | 1 | Descriptor fetch request, held until fetch_valid |
| fetch_addr | output | AW | Address of the descriptor to fetch |
| fetch_valid | input | 1 | Fetched descriptor fields are valid this cycle |
| fetch_own | input | 1 | Ownership bit of fetched descriptor (1 = DMA) |
| fetch_chain | input | 1 | Descriptor uses its next-address field |
| fetch_ring_end | input | 1 | Descriptor is the last of the ring |
| fetch_next | input | AW | Next-address field of fetched descriptor |
| xfer_req | output | 1 | Frame transfer request to datapath |
| xfer_addr | output | AW | Descriptor address for the transfer |
| xfer_done | input | 1 | Datapath finished the frame |
| wb_valid | output | 1 | One-cycle strobe: return ownership to software |
| wb_addr | output | AW | Descriptor address to write back |
| rx_state | output | 2 | 00 stopped, 01 running, 10 suspended |
| susp_flag | output | 1 | Sticky suspended flag (status bit 7) |
| stop_flag | output | 1 | Sticky stopped flag |

## Verification
The advance logic is driven through three descriptor shapes: plain stride, chained with an unaligned next address, and ring end. A wrong selection shows up directly as a different fetch address. Ownership is driven both ways on the same address: a refused descriptor followed by a poll, then an accepted one. This separates suspension from the resumption of running. Stops are placed in three spots: during a transfer, during a fetch, and while suspended. One of them has run_en raised again before the frame completes. Together these show whether the engine waits for the frame, passes through stopped, and resumes from the saved pointer rather than from a changed list base.

// File: rtl/rxdc_pkg.sv
// Package: shared types and state codes for the receive descriptor run controller.
// Assumes: nothing beyond IEEE 1800-2017.
package rxdc_pkg;

    // Internal engine phases; running covers FETCH, XFER and WB.
    typedef enum logic [2:0] {
        ENG_STOP  = 3'd0,
        ENG_FETCH = 3'd1,
        ENG_XFER  = 3'd2,
        ENG_WB    = 3'd3,
        ENG_SUSP  = 3'd4
    } eng_state_e;

    // Visible state encoding.
    localparam logic [1:0] VIS_STOPPED   = 2'b00;
    localparam logic [1:0] VIS_RUNNING   = 2'b01;
    localparam logic [1:0] VIS_SUSPENDED = 2'b10;

    // Flag indices in the sticky status vector / clear vector.
    localparam int FLAG_SUSP = 0;
    localparam int FLAG_STOP = 1;
    localparam int NUM_FLAGS = 2;

endpackage

// File: rtl/rxdc_fsm.sv
// Module: rxdc_fsm
// Sequences the engine: stopped -> fetch -> transfer -> write-back -> fetch,
// with suspension on an unowned descriptor and deferred stop.
// Assumes: fetch_valid only matters while fetch_req is high, xfer_done only
// while xfer_req is high; run_en is a level from software.
module rxdc_fsm
    import rxdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       poll_req,
    input  logic       fetch_valid,
    input  logic       fetch_own,
    input  logic       xfer_done,
    output logic       ld_base,
    output logic       take_desc,
    output logic       advance,
    output logic       set_susp,
    output logic       set_stop,
    output logic       fetch_req,
    output logic       xfer_req,
    output logic       wb_valid,
    output logic [1:0] vis_state
);

    eng_state_e st_q, st_d;
    logic       started_q;
    logic       stop_pend_q;
    logic       in_run;
    logic       want_stop;

    assign in_run    = (st_q == ENG_FETCH) || (st_q == ENG_XFER) || (st_q == ENG_WB);
    assign want_stop = stop_pend_q || !run_en;

    // Next-state and one-cycle control strobes.
    always_comb begin
        st_d      = st_q;
        ld_base   = 1'b0;
        take_desc = 1'b0;
        advance   = 1'b0;
        set_susp  = 1'b0;
        set_stop  = 1'b0;
        unique case (st_q)
            ENG_STOP: begin
                if (run_en) begin
                    st_d    = ENG_FETCH;
                    ld_base = !started_q;
                end
            end
            ENG_FETCH: begin
                if (fetch_valid) begin
                    if (want_stop) begin
                        st_d     = ENG_STOP;
                        set_stop = 1'b1;
                    end else if (fetch_own) begin
                        st_d      = ENG_XFER;
                        take_desc = 1'b1;
                    end else begin
                        st_d     = ENG_SUSP;
                        set_susp = 1'b1;
                    end
                end
            end
            ENG_XFER: begin
                if (xfer_done) begin
                    st_d = ENG_WB;
                end
            end
            ENG_WB: begin
                advance = 1'b1;
                if (want_stop) begin
                    st_d     = ENG_STOP;
                    set_stop = 1'b1;
                end else begin
                    st_d = ENG_FETCH;
                end
            end
            ENG_SUSP: begin
                if (!run_en) begin
                    st_d     = ENG_STOP;
                    set_stop = 1'b1;
                end else if (poll_req) begin
                    st_d = ENG_FETCH;
                end
            end
            default: st_d = ENG_STOP;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ENG_STOP;
        else        st_q <= st_d;
    end

    // Remembers that a start has happened since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       started_q <= 1'b0;
        else if (ld_base) started_q <= 1'b1;
    end

    // Latches a stop request seen while running until the engine halts.
    always_ff @(posedge clk) begin
        if (!rst_n)                 stop_pend_q <= 1'b0;
        else if (st_d == ENG_STOP)  stop_pend_q <= 1'b0;
        else if (in_run && !run_en) stop_pend_q <= 1'b1;
    end

    // Handshake outputs and visible state decode.
    always_comb begin
        fetch_req = (st_q == ENG_FETCH);
        xfer_req  = (st_q == ENG_XFER);
        wb_valid  = (st_q == ENG_WB);
        if (st_q == ENG_STOP)      vis_state = VIS_STOPPED;
        else if (st_q == ENG_SUSP) vis_state = VIS_SUSPENDED;
        else                       vis_state = VIS_RUNNING;
    end

endmodule

// File: rtl/rxdc_ptr.sv
// Module: rxdc_ptr
// Holds the current descriptor pointer and the link fields of the descriptor
// being processed; computes the next pointer on write-back.
// Assumes: descriptors are DESC_BYTES apart and DESC_BYTES is a power of two.
module rxdc_ptr #(
    parameter int AW         = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] list_base,
    input  logic          ld_base,
    input  logic          take_desc,
    input  logic          advance,
    input  logic          desc_chain,
    input  logic          desc_ring_end,
    input  logic [AW-1:0] desc_next,
    output logic [AW-1:0] cur_ptr
);

    localparam int          ALIGN_BITS = $clog2(DESC_BYTES);
    localparam logic [AW-1:0] STRIDE   = AW'(DESC_BYTES);

    logic [AW-1:0] align_mask;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] next_q;
    logic          chain_q;
    logic          rend_q;
    logic [AW-1:0] seq_ptr;
    logic [AW-1:0] adv_ptr;

    // Alignment mask built per bit; low ALIGN_BITS cleared.
    for (genvar b = 0; b < AW; b++) begin : g_mask
        if (b < ALIGN_BITS) begin : g_lo
            assign align_mask[b] = 1'b0;
        end else begin : g_hi
            assign align_mask[b] = 1'b1;
        end
    end

    assign seq_ptr = ptr_q + STRIDE;

    // Choose the following descriptor address.
    always_comb begin
        if (chain_q)     adv_ptr = next_q;
        else if (rend_q) adv_ptr = list_base & align_mask;
        else             adv_ptr = seq_ptr;
    end

    // Pointer register: base load on first start, advance after write-back.
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr_q <= '0;
        else if (ld_base) ptr_q <= list_base & align_mask;
        else if (advance) ptr_q <= adv_ptr;
    end

    // Capture link fields of an accepted descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q  <= '0;
            chain_q <= 1'b0;
            rend_q  <= 1'b0;
        end else if (take_desc) begin
            next_q  <= desc_next & align_mask;
            chain_q <= desc_chain;
            rend_q  <= desc_ring_end;
        end
    end

    assign cur_ptr = ptr_q;

endmodule

// File: rtl/rxdc_flags.sv
// Module: rxdc_flags
// Sticky status flags with write-1-to-clear; a set in the same cycle wins.
// Assumes: set and clear inputs are single-cycle strobes.
module rxdc_flags #(
    parameter int NF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_vec,
    input  logic [NF-1:0] clr_vec,
    output logic [NF-1:0] flags
);

    for (genvar i = 0; i < NF; i++) begin : g_flag
        logic f_q;
        // One sticky bit: set dominates clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          f_q <= 1'b0;
            else if (set_vec[i]) f_q <= 1'b1;
            else if (clr_vec[i]) f_q <= 1'b0;
        end
        assign flags[i] = f_q;
    end

endmodule

// File: rtl/rx_desc_run_ctrl.sv
// Module: rx_desc_run_ctrl
// Top of the receive descriptor run controller: joins the sequencer, the
// pointer unit and the sticky flags.
// Assumes: the fetch unit and frame datapath obey the req/valid and req/done
// handshakes described in the brief.
module rx_desc_run_ctrl
    import rxdc_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DESC_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic [AW-1:0] list_base,
    input  logic          poll_req,
    input  logic [1:0]    clr_flags,
    output logic          fetch_req,
    output logic [AW-1:0] fetch_addr,
    input  logic          fetch_valid,
    input  logic          fetch_own,
    input  logic          fetch_chain,
    input  logic          fetch_ring_end,
    input  logic [AW-1:0] fetch_next,
    output logic          xfer_req,
    output logic [AW-1:0] xfer_addr,
    input  logic          xfer_done,
    output logic          wb_valid,
    output logic [AW-1:0] wb_addr,
    output logic [1:0]    rx_state,
    output logic          susp_flag,
    output logic          stop_flag
);

    logic                 ld_base;
    logic                 take_desc;
    logic                 advance;
    logic                 set_susp;
    logic                 set_stop;
    logic [AW-1:0]        cur_ptr;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] flag_vec;

    rxdc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .poll_req    (poll_req),
        .fetch_valid (fetch_valid),
        .fetch_own   (fetch_own),
        .xfer_done   (xfer_done),
        .ld_base     (ld_base),
        .take_desc   (take_desc),
        .advance     (advance),
        .set_susp    (set_susp),
        .set_stop    (set_stop),
        .fetch_req   (fetch_req),
        .xfer_req    (xfer_req),
        .wb_valid    (wb_valid),
        .vis_state   (rx_state)
    );

    rxdc_ptr #(
        .AW         (AW),
        .DESC_BYTES (DESC_BYTES)
    ) u_ptr (
        .clk           (clk),
        .rst_n         (rst_n),
        .list_base     (list_base),
        .ld_base       (ld_base),
        .take_desc     (take_desc),
        .advance       (advance),
        .desc_chain    (fetch_chain),
        .desc_ring_end (fetch_ring_end),
        .desc_next     (fetch_next),
        .cur_ptr       (cur_ptr)
    );

    // Route flag set strobes by index.
    always_comb begin
        set_vec            = '0;
        set_vec[FLAG_SUSP] = set_susp;
        set_vec[FLAG_STOP] = set_stop;
    end

    rxdc_flags #(
        .NF (NUM_FLAGS)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_flags),
        .flags   (flag_vec)
    );

    assign fetch_addr = cur_ptr;
    assign xfer_addr  = cur_ptr;
    assign wb_addr    = cur_ptr;
    assign susp_flag  = flag_vec[FLAG_SUSP];
    assign stop_flag  = flag_vec[FLAG_STOP];

endmodule

// File: rtl/rx_desc_run_ctrl_chk.sv
// Module: rx_desc_run_ctrl_chk
// Port-level protocol properties for rx_desc_run_ctrl, bound to every instance.
// Assumes: synchronous active-low reset held for at least one clock.
module rx_desc_run_ctrl_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run_en,
    input logic          poll_req,
    input logic [1:0]    clr_flags,
    input logic          fetch_req,
    input logic [AW-1:0] fetch_addr,
    input logic          fetch_valid,
    input logic          fetch_own,
    input logic          xfer_req,
    input logic [AW-1:0] xfer_addr,
    input logic          xfer_done,
    input logic          wb_valid,
    input logic [AW-1:0] wb_addr,
    input logic [1:0]    rx_state,
    input logic          susp_flag,
    input logic          stop_flag
);

    p_legal_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_state != 2'b11);

    p_one_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fetch_req, xfer_req, wb_valid}));

    p_idle_when_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state == 2'b00) |-> (!fetch_req && !xfer_req && !wb_valid));

    p_xfer_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_addr)));

    p_wb_follows_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_done) |=> (wb_valid && wb_addr == $past(xfer_addr)));

    p_wb_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid);

    p_unowned_no_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_valid && !fetch_own) |=> (rx_state != 2'b01 && !xfer_req));

    p_poll_refetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state == 2'b10 && poll_req && run_en)
            |=> (fetch_req && fetch_addr == $past(fetch_addr)));

    p_susp_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_flag && !clr_flags[0]) |=> susp_flag);

    p_stop_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_flag && !clr_flags[1]) |=> stop_flag);

    p_stop_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state == 2'b00 && $past(rx_state) != 2'b00) |-> stop_flag);

    p_susp_stop_now_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state == 2'b10 && !run_en) |=> (rx_state == 2'b00));

endmodule

bind rx_desc_run_ctrl rx_desc_run_ctrl_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .poll_req    (poll_req),
    .clr_flags   (clr_flags),
    .fetch_req   (fetch_req),
    .fetch_addr  (fetch_addr),
    .fetch_valid (fetch_valid),
    .fetch_own   (fetch_own),
    .xfer_req    (xfer_req),
    .xfer_addr   (xfer_addr),
    .xfer_done   (xfer_done),
    .wb_valid    (wb_valid),
    .wb_addr     (wb_addr),
    .rx_state    (rx_state),
    .susp_flag   (susp_flag),
    .stop_flag   (stop_flag)
);

// File: tb/tb_rx_desc_run_ctrl.sv
// Directed bench for rx_desc_run_ctrl: one task per scenario, inputs driven
// and outputs sampled on the falling edge.
module tb_rx_desc_run_ctrl;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic [AW-1:0] list_base = '0;
    logic          poll_req = 1'b0;
    logic [1:0]    clr_flags = 2'b00;
    logic          fetch_req;
    logic [AW-1:0] fetch_addr;
    logic          fetch_valid = 1'b0;
    logic          fetch_own = 1'b0;
    logic          fetch_chain = 1'b0;
    logic          fetch_ring_end = 1'b0;
    logic [AW-1:0] fetch_next = '0;
    logic          xfer_req;
    logic [AW-1:0] xfer_addr;
    logic          xfer_done = 1'b0;
    logic          wb_valid;
    logic [AW-1:0] wb_addr;
    logic [1:0]    rx_state;
    logic          susp_flag;
    logic          stop_flag;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;  // 250 MHz

    rx_desc_run_ctrl #(.AW(AW), .DESC_BYTES(16)) dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .list_base(list_base),
        .poll_req(poll_req), .clr_flags(clr_flags),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_valid(fetch_valid),
        .fetch_own(fetch_own), .fetch_chain(fetch_chain),
        .fetch_ring_end(fetch_ring_end), .fetch_next(fetch_next),
        .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_done(xfer_done),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .rx_state(rx_state),
        .susp_flag(susp_flag), .stop_flag(stop_flag)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Wait for a fetch, check its address, answer with the given fields.
    task automatic serve_fetch(input string req, input logic [AW-1:0] exp_addr,
                               input logic own, input logic chain,
                               input logic rend, input logic [AW-1:0] nxt);
        for (int i = 0; i < 16 && !fetch_req; i++) tick();
        chk(req, "fetch_req", 64'(fetch_req), 64'd1);
        chk(req, "fetch_addr", 64'(fetch_addr), 64'(exp_addr));
        fetch_valid = 1'b1; fetch_own = own; fetch_chain = chain;
        fetch_ring_end = rend; fetch_next = nxt;
        tick();
        fetch_valid = 1'b0; fetch_own = 1'b0; fetch_chain = 1'b0;
        fetch_ring_end = 1'b0; fetch_next = '0;
    endtask

    // Called right after an owned fetch: hold transfer, complete, see write-back.
    task automatic serve_xfer(input logic [AW-1:0] exp_addr, input int hold);
        chk("R3", "xfer_req", 64'(xfer_req), 64'd1);
        chk("R3", "xfer_addr", 64'(xfer_addr), 64'(exp_addr));
        for (int i = 0; i < hold; i++) begin
            tick();
            chk("R3", "xfer_req held", 64'(xfer_req), 64'd1);
        end
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
        chk("R4", "wb_valid", 64'(wb_valid), 64'd1);
        chk("R4", "wb_addr", 64'(wb_addr), 64'(exp_addr));
        tick();
        chk("R4", "wb_valid single", 64'(wb_valid), 64'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1", "rx_state", 64'(rx_state), 64'd0);
        chk("R1", "reqs", 64'({fetch_req, xfer_req, wb_valid}), 64'd0);
        chk("R1", "flags", 64'({susp_flag, stop_flag}), 64'd0);
    endtask

    // First start, three advance rules, then an unowned descriptor.
    task automatic t_run_ring();
        list_base = 32'h1000;
        run_en = 1'b1;
        tick();
        chk("R2", "rx_state running", 64'(rx_state), 64'd1);
        serve_fetch("R2", 32'h1000, 1'b1, 1'b0, 1'b0, '0);
        serve_xfer(32'h1000, 3);
        serve_fetch("R5", 32'h1010, 1'b1, 1'b1, 1'b0, 32'h2000);  // stride
        serve_xfer(32'h1010, 0);
        serve_fetch("R5", 32'h2000, 1'b1, 1'b0, 1'b1, '0);        // chained
        serve_xfer(32'h2000, 1);
        serve_fetch("R5", 32'h1000, 1'b0, 1'b0, 1'b0, '0);        // ring end wrap
        chk("R6", "rx_state suspended", 64'(rx_state), 64'd2);
        chk("R6", "susp_flag", 64'(susp_flag), 64'd1);
        chk("R6", "no xfer_req", 64'(xfer_req), 64'd0);
    endtask

    // Poll refetch, sticky flag, then a stop pending across a re-raised run bit.
    task automatic t_poll_and_stop();
        poll_req = 1'b1; tick(); poll_req = 1'b0;
        serve_fetch("R7", 32'h1000, 1'b0, 1'b0, 1'b0, '0);
        chk("R7", "still suspended", 64'(rx_state), 64'd2);
        repeat (3) tick();
        chk("R8", "susp_flag sticky", 64'(susp_flag), 64'd1);
        clr_flags = 2'b01; tick(); clr_flags = 2'b00;
        chk("R8", "susp_flag cleared", 64'(susp_flag), 64'd0);
        poll_req = 1'b1; tick(); poll_req = 1'b0;
        serve_fetch("R7", 32'h1000, 1'b1, 1'b0, 1'b0, '0);
        chk("R7", "running again", 64'(rx_state), 64'd1);
        chk("R7", "xfer_req", 64'(xfer_req), 64'd1);
        list_base = 32'h3000;
        run_en = 1'b0;
        tick();
        chk("R9", "running while frame open", 64'(rx_state), 64'd1);
        chk("R9", "xfer_req held", 64'(xfer_req), 64'd1);
        run_en = 1'b1;
        tick();
        chk("R11", "stop not cancelled, still xfer", 64'(xfer_req), 64'd1);
        xfer_done = 1'b1; tick(); xfer_done = 1'b0;
        chk("R9", "wb before stop", 64'(wb_valid), 64'd1);
        chk("R9", "state during wb", 64'(rx_state), 64'd1);
        tick();
        chk("R11", "passes through stopped", 64'(rx_state), 64'd0);
        chk("R9", "stop_flag", 64'(stop_flag), 64'd1);
        tick();
        chk("R10", "fetch_req after restart", 64'(fetch_req), 64'd1);
        chk("R10", "resume addr not base", 64'(fetch_addr), 64'h1010);
    endtask

    // Stop during fetch, stop from suspended, poll while stopped, alignment.
    task automatic t_stop_paths();
        run_en = 1'b0;
        tick();
        chk("R12", "fetch still open", 64'(fetch_req), 64'd1);
        fetch_valid = 1'b1; fetch_own = 1'b1;
        tick();
        fetch_valid = 1'b0; fetch_own = 1'b0;
        chk("R12", "stopped after fetch", 64'(rx_state), 64'd0);
        chk("R12", "descriptor discarded", 64'(xfer_req), 64'd0);
        run_en = 1'b1;
        tick();
        serve_fetch("R12", 32'h1010, 1'b0, 1'b0, 1'b0, '0);
        chk("R6", "suspended", 64'(rx_state), 64'd2);
        clr_flags = 2'b10; run_en = 1'b0;
        tick();
        clr_flags = 2'b00;
        chk("R12", "stop from suspended", 64'(rx_state), 64'd0);
        chk("R8", "set beats clear", 64'(stop_flag), 64'd1);
        clr_flags = 2'b10; tick(); clr_flags = 2'b00;
        chk("R8", "stop_flag cleared", 64'(stop_flag), 64'd0);
        chk("R8", "susp_flag untouched", 64'(susp_flag), 64'd1);
        poll_req = 1'b1; tick(); poll_req = 1'b0;
        tick();
        chk("R7", "poll ignored when stopped", 64'(fetch_req), 64'd0);
        chk("R7", "state stopped", 64'(rx_state), 64'd0);
        run_en = 1'b1;
        tick();
        serve_fetch("R12", 32'h1010, 1'b1, 1'b1, 1'b0, 32'h2004);
        serve_xfer(32'h1010, 0);
        serve_fetch("R5", 32'h2000, 1'b0, 1'b0, 1'b0, '0);
    endtask

    initial begin
        t_reset();
        t_run_ring();
        t_poll_and_stop();
        t_stop_paths();
        run_en = 1'b0;
        repeat (3) tick();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule